// File: doc/BRIEF.md
# Shared Debug-Event Pin Qualifier

This block reads one active-low debug-event pin and turns it into three separate, qualified outcomes. In normal operation, a held assertion becomes a one-cycle debug-entry request to the processor. While the JTAG TAP rests in test-logic-reset, a held assertion sets a sticky enable for the on-chip emulation logic. During a low-power state, the pin at once asks the clock controller to restart. If the pin is then held long enough on the restarted clock, the block signals an exit from low power straight into debug mode.

Each function has its own clock domain, its own minimum-hold rule and its own reset behaviour. The pin passes through a separate synchronizer chain in each domain before it is counted. The debug-entry and wake counters run on the system clock. The emulation-enable counter runs on the test clock and shares no state with the other two counters. The restart request is a purely combinational path, so it works while the system clock is stopped.

Top module: `dbgpin_ctrl`

## Requirements
- R1: When the synchronized pin (low = asserted) is seen low on at least three consecutive rising system-clock edges, debug_req pulses exactly once.
- R2: If the pin is released before the system-clock hold count completes, the count returns to zero and no debug_req or wake_to_debug is produced.
- R3: While sys_rst is high, pin assertions never produce debug_req.
- R4: While in_debug is high, the pin produces no debug_req. After in_debug falls, a new request is accepted only once the pin has been seen released.
- R5: debug_req lasts exactly one system-clock cycle, however long the pin is held.
- R6: With two synchronizer stages, debug_req is high in the cycle that follows the fifth rising edge, counting the first edge that samples the pin low as edge one. It is still low after the fourth edge.
- R7: emu_enable sets only when the pin is held low across at least two rising test_clk edges while tap_in_tlr is high and neither pwr_on_rst nor tap_rst is high. A single-edge hold does not set it, and neither does a hold taken while tap_in_tlr is low.
- R8: Once set, emu_enable stays high through pin release, TAP state changes, sys_rst and low-power transitions. Only pwr_on_rst or tap_rst clears it.
- R9: clock_restart is high whenever in_lowpower is high and the pin is low, with no clock edge needed. Otherwise it is low.
- R10: In low power, a pin held low for at least three rising system-clock edges produces exactly one single-cycle wake_to_debug pulse. A shorter hold produces none.
- R11: While in_lowpower is high, debug_req is never raised.
- R12: After pwr_on_rst, debug_req, wake_to_debug, emu_enable and clock_restart are all low while the pin is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| test_clk | input | 1 | JTAG test clock |
| pwr_on_rst | input | 1 | Power-on reset, active high, sampled synchronously in both domains |
| tap_rst | input | 1 | TAP reset, active high, sampled on test_clk; clears emu_enable |
| sys_rst | input | 1 | System reset active flag; blocks debug entry |
| tap_in_tlr | input | 1 | High while the TAP is in test-logic-reset |
| in_debug | input | 1 | High while the processor is in debug mode |
| in_lowpower | input | 1 | High while the system is in a low-power state |
| dbg_evt_n | input | 1 | Shared debug-event pin, active low, asynchronous |
| debug_req | output | 1 | One-cycle debug-entry request |
| emu_enable | output | 1 | Sticky emulation-logic enable (test_clk domain) |
| clock_restart | output | 1 | Combinational clock-controller restart request |
| wake_to_debug | output | 1 | One-cycle low-power exit into debug mode |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a hold of three for debug entry and wake-up, and a hold of two for the emulation enable. With these small values, the just-short and exactly-enough holds fall only a few cycles apart, so both sides of every threshold are driven directly. The five-edge entry latency can be pinned to one exact cycle. The test clock is slower than the system clock and unrelated to it, so a pin hold can be placed on an exact number of test-clock edges while the system-domain counter sees a different count.

// File: rtl/dbgpin_pkg.sv
`timescale 1ns/1ps
package dbgpin_pkg;

    // Width of every hold counter; hold parameters must stay below 2**CNT_W.
    localparam int CNT_W = 4;

    typedef logic [CNT_W-1:0] hold_cnt_t;

    // State of one hold qualifier: armed means a new pulse may be produced.
    typedef struct packed {
        logic      armed;
        hold_cnt_t count;
    } qual_state_t;

    localparam qual_state_t QUAL_IDLE = '{armed: 1'b1, count: '0};

    function automatic hold_cnt_t cnt_step(hold_cnt_t c);
        return c + hold_cnt_t'(1);
    endfunction

    function automatic logic hold_done(hold_cnt_t c, int unsigned hold);
        return c == hold_cnt_t'(hold - 1);
    endfunction

endpackage

// File: rtl/dbgpin_sync.sv
`timescale 1ns/1ps
module dbgpin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= RST_VAL;
                end else if (i == 0) begin
                    chain[i] <= d;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgpin_qual.sv
`timescale 1ns/1ps
module dbgpin_qual
    import dbgpin_pkg::*;
#(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_low,   // synchronized, 1 = asserted
    input  logic en,        // counting allowed
    input  logic hold_off,  // disarm until the pin is seen released
    output logic pulse
);
    qual_state_t st;

    initial begin
        assert (HOLD >= 1 && HOLD < (1 << CNT_W))
            else $error("HOLD out of range for counter width");
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= QUAL_IDLE;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (hold_off) begin
                st.armed <= 1'b0;
                st.count <= '0;
            end else if (!pin_low) begin
                st.armed <= 1'b1;
                st.count <= '0;
            end else if (!en || !st.armed) begin
                st.count <= '0;
            end else if (hold_done(st.count, HOLD)) begin
                pulse    <= 1'b1;
                st.armed <= 1'b0;
                st.count <= '0;
            end else begin
                st.count <= cnt_step(st.count);
            end
        end
    end

    // R1 / R2: a pulse only follows a qualified low sample
    a_r2_pulse_after_low: assert property (@(posedge clk) disable iff (rst)
        pulse |-> ($past(pin_low) && $past(en) && !$past(hold_off)));

    // R5 / R10: pulses are one cycle wide
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/dbgpin_emu.sv
`timescale 1ns/1ps
module dbgpin_emu
    import dbgpin_pkg::*;
#(
    parameter int HOLD = 2
) (
    input  logic test_clk,
    input  logic clr,        // power-on or TAP reset
    input  logic tap_in_tlr,
    input  logic pin_low,    // synchronized in test_clk domain
    output logic enable
);
    hold_cnt_t cnt;

    always_ff @(posedge test_clk) begin
        if (clr) begin
            cnt    <= '0;
            enable <= 1'b0;
        end else if (!tap_in_tlr || !pin_low) begin
            cnt <= '0;
        end else if (hold_done(cnt, HOLD)) begin
            enable <= 1'b1;
            cnt    <= '0;
        end else begin
            cnt <= cnt_step(cnt);
        end
    end

    // R8: only a reset clears the sticky enable
    a_r8_emu_sticky: assert property (@(posedge test_clk) disable iff (clr)
        $past(enable) |-> enable);

    // R7: a rising enable needs the TAP in test-logic-reset and a low pin
    a_r7_emu_qualified: assert property (@(posedge test_clk) disable iff (clr)
        $rose(enable) |-> ($past(tap_in_tlr) && $past(pin_low)));
endmodule

// File: rtl/dbgpin_ctrl.sv
`timescale 1ns/1ps
module dbgpin_ctrl
    import dbgpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DBG_HOLD    = 3,
    parameter int WAKE_HOLD   = 3,
    parameter int EMU_HOLD    = 2
) (
    input  logic clk,
    input  logic test_clk,
    input  logic pwr_on_rst,
    input  logic tap_rst,
    input  logic sys_rst,
    input  logic tap_in_tlr,
    input  logic in_debug,
    input  logic in_lowpower,
    input  logic dbg_evt_n,
    output logic debug_req,
    output logic emu_enable,
    output logic clock_restart,
    output logic wake_to_debug
);
    logic pin_sys_n, pin_tck_n;
    logic emu_clr;
    logic dbg_en, wake_en;

    assign emu_clr = pwr_on_rst | tap_rst;

    dbgpin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sys (
        .clk (clk),
        .rst (pwr_on_rst),
        .d   (dbg_evt_n),
        .q   (pin_sys_n)
    );

    dbgpin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_tck (
        .clk (test_clk),
        .rst (emu_clr),
        .d   (dbg_evt_n),
        .q   (pin_tck_n)
    );

    // Debug entry: blocked by reset, by debug mode and during low power.
    assign dbg_en  = !sys_rst && !in_debug && !in_lowpower;
    // Wake-up: only counted while the system reports low power.
    assign wake_en = in_lowpower && !sys_rst;

    dbgpin_qual #(.HOLD(DBG_HOLD)) u_dbg_qual (
        .clk      (clk),
        .rst      (pwr_on_rst),
        .pin_low  (!pin_sys_n),
        .en       (dbg_en),
        .hold_off (in_debug),
        .pulse    (debug_req)
    );

    dbgpin_qual #(.HOLD(WAKE_HOLD)) u_wake_qual (
        .clk      (clk),
        .rst      (pwr_on_rst),
        .pin_low  (!pin_sys_n),
        .en       (wake_en),
        .hold_off (1'b0),
        .pulse    (wake_to_debug)
    );

    dbgpin_emu #(.HOLD(EMU_HOLD)) u_emu (
        .test_clk   (test_clk),
        .clr        (emu_clr),
        .tap_in_tlr (tap_in_tlr),
        .pin_low    (!pin_tck_n),
        .enable     (emu_enable)
    );

    // Restart path needs no running clock.
    assign clock_restart = in_lowpower && !dbg_evt_n;

    // R3: no request may follow a cycle with system reset active
    a_r3_no_req_in_reset: assert property (@(posedge clk) disable iff (pwr_on_rst)
        debug_req |-> !$past(sys_rst));

    // R4: no request may follow a cycle spent in debug mode
    a_r4_no_req_in_debug: assert property (@(posedge clk) disable iff (pwr_on_rst)
        debug_req |-> !$past(in_debug));

    // R11: no debug request issued from low power
    a_r11_no_req_lowpower: assert property (@(posedge clk) disable iff (pwr_on_rst)
        debug_req |-> !$past(in_lowpower));

    // R10: wake pulse only from low power and one cycle wide
    a_r10_wake_from_lowpower: assert property (@(posedge clk) disable iff (pwr_on_rst)
        wake_to_debug |-> ($past(in_lowpower) && !$past(wake_to_debug)));
endmodule

// File: tb/dbgpin_ctrl_test.sv
`timescale 1ns/1ps
module dbgpin_ctrl_test;
    logic clk = 1'b0;
    logic test_clk = 1'b0;
    logic pwr_on_rst = 1'b1;
    logic tap_rst = 1'b1;
    logic sys_rst = 1'b0;
    logic tap_in_tlr = 1'b0;
    logic in_debug = 1'b0;
    logic in_lowpower = 1'b0;
    logic dbg_evt_n = 1'b1;
    logic debug_req, emu_enable, clock_restart, wake_to_debug;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scoreboard: expected pulse counts and emu level per test window
    string tag_q[$];
    int    req_q[$];
    int    wake_q[$];
    int    emu_q[$];
    int    req_seen = 0;
    int    wake_seen = 0;

    always #2 clk = ~clk;        // 250 MHz
    always #5 test_clk = ~test_clk;

    dbgpin_ctrl uut (
        .clk           (clk),
        .test_clk      (test_clk),
        .pwr_on_rst    (pwr_on_rst),
        .tap_rst       (tap_rst),
        .sys_rst       (sys_rst),
        .tap_in_tlr    (tap_in_tlr),
        .in_debug      (in_debug),
        .in_lowpower   (in_lowpower),
        .dbg_evt_n     (dbg_evt_n),
        .debug_req     (debug_req),
        .emu_enable    (emu_enable),
        .clock_restart (clock_restart),
        .wake_to_debug (wake_to_debug)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: accumulate pulses, compare when an expectation arrives
    always @(negedge clk) begin
        if (debug_req) req_seen++;
        if (wake_to_debug) wake_seen++;
        if (tag_q.size() > 0) begin
            string t;
            t = tag_q.pop_front();
            chk({t, " debug_req pulses"}, req_seen, req_q.pop_front());
            chk({t, " wake_to_debug pulses"}, wake_seen, wake_q.pop_front());
            chk({t, " emu_enable"}, int'(emu_enable), emu_q.pop_front());
            req_seen  = 0;
            wake_seen = 0;
        end
    end

    task automatic sys_cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic tck_cycles(int n);
        repeat (n) @(posedge test_clk);
        #1;
    endtask

    task automatic expect_window(string tag, int req, int wake, int emu);
        sys_cycles(8);
        tag_q.push_back(tag);
        req_q.push_back(req);
        wake_q.push_back(wake);
        emu_q.push_back(emu);
        wait (tag_q.size() == 0);
        sys_cycles(1);
    endtask

    task automatic hold_sys(int n);
        dbg_evt_n = 1'b0;
        sys_cycles(n);
        dbg_evt_n = 1'b1;
    endtask

    task automatic hold_tck(int n);
        tck_cycles(1);
        dbg_evt_n = 1'b0;
        tck_cycles(n);
        dbg_evt_n = 1'b1;
        tck_cycles(4);
        sys_cycles(1);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        sys_cycles(4);
        tck_cycles(3);
        pwr_on_rst = 1'b0;
        tap_rst    = 1'b0;
        sys_cycles(2);
        // R12 reset state
        chk("R12 debug_req after reset", int'(debug_req), 0);
        chk("R12 wake_to_debug after reset", int'(wake_to_debug), 0);
        chk("R12 emu_enable after reset", int'(emu_enable), 0);
        chk("R12 clock_restart after reset", int'(clock_restart), 0);
        expect_window("R12 idle", 0, 0, 0);

        // R6 exact latency
        dbg_evt_n = 1'b0;
        sys_cycles(4);
        chk("R6 debug_req after 4th edge", int'(debug_req), 0);
        sys_cycles(1);
        chk("R6 debug_req after 5th edge", int'(debug_req), 1);
        dbg_evt_n = 1'b1;
        expect_window("R6 latency window", 1, 0, 0);

        // R1 exactly three edges, R2 two edges
        hold_sys(3);
        expect_window("R1 hold of three", 1, 0, 0);
        hold_sys(2);
        expect_window("R2 hold of two", 0, 0, 0);
        hold_sys(1);
        sys_cycles(1);
        hold_sys(2);
        expect_window("R2 broken hold", 0, 0, 0);

        // R5 long hold yields one single-cycle pulse
        hold_sys(20);
        expect_window("R5 long hold", 1, 0, 0);

        // R3 system reset blocks
        sys_rst = 1'b1;
        hold_sys(10);
        sys_cycles(4);
        sys_rst = 1'b0;
        expect_window("R3 during sys_rst", 0, 0, 0);

        // R4 debug mode blocks; release needed after exit
        in_debug = 1'b1;
        dbg_evt_n = 1'b0;
        sys_cycles(10);
        in_debug = 1'b0;
        sys_cycles(10);
        dbg_evt_n = 1'b1;
        expect_window("R4 held through debug exit", 0, 0, 0);
        hold_sys(8);
        expect_window("R4 after release", 1, 0, 0);

        // R7 emulation enable (debug entry masked)
        in_debug = 1'b1;
        tap_in_tlr = 1'b1;
        hold_tck(1);
        expect_window("R7 one test_clk edge", 0, 0, 0);
        tap_in_tlr = 1'b0;
        hold_tck(4);
        expect_window("R7 TAP not in reset state", 0, 0, 0);
        tap_in_tlr = 1'b1;
        hold_tck(2);
        expect_window("R7 two test_clk edges", 0, 0, 1);

        // R8 sticky
        tap_in_tlr = 1'b0;
        sys_rst = 1'b1;
        sys_cycles(3);
        sys_rst = 1'b0;
        in_lowpower = 1'b1;
        sys_cycles(3);
        in_lowpower = 1'b0;
        expect_window("R8 survives other events", 0, 0, 1);
        tap_rst = 1'b1;
        tck_cycles(2);
        tap_rst = 1'b0;
        expect_window("R8 cleared by tap_rst", 0, 0, 0);
        tap_in_tlr = 1'b1;
        hold_tck(3);
        tap_in_tlr = 1'b0;
        expect_window("R8 set again", 0, 0, 1);
        pwr_on_rst = 1'b1;
        tck_cycles(2);
        sys_cycles(2);
        pwr_on_rst = 1'b0;
        expect_window("R8 cleared by pwr_on_rst", 0, 0, 0);
        in_debug = 1'b0;
        sys_cycles(6);

        // R9 restart path
        in_lowpower = 1'b1;
        sys_cycles(2);
        chk("R9 restart idle in low power", int'(clock_restart), 0);
        dbg_evt_n = 1'b0;
        #1;
        chk("R9 restart without clock edge", int'(clock_restart), 1);
        dbg_evt_n = 1'b1;
        #1;
        chk("R9 restart drops on release", int'(clock_restart), 0);
        sys_cycles(4);

        // R10 / R11 wake-up in low power
        hold_sys(3);
        expect_window("R10 R11 wake hold of three", 0, 1, 0);
        hold_sys(2);
        expect_window("R10 wake hold of two", 0, 0, 0);
        in_lowpower = 1'b0;
        dbg_evt_n = 1'b0;
        #1;
        chk("R9 restart outside low power", int'(clock_restart), 0);
        dbg_evt_n = 1'b1;
        sys_cycles(6);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule